// File: doc/BRIEF.md
# Privilege-Mode Virtual Address Segment Decoder

This block sorts a virtual address into one of three outcomes before any translation takes place. It takes the address, three privilege flags and an addressing-width flag. The address either goes to the translation lookaside buffer (TLB) for lookup, or is turned straight into a physical address with no mapping, or is refused as a disallowed address. The decision depends on the active privilege level and on whether 32-bit or 64-bit addressing is in force. Each level has its own permission table for each width, and the 64-bit supervisor space has gaps that are refused.

The block is purely combinational, so its outputs follow its inputs within the same cycle. A memory pipeline stage uses the result code to choose the next step: start a TLB probe with the lookup address, use the unmapped physical address directly, or raise an address exception. The TLB, exception delivery and cache attributes belong to other blocks.

Top module: `vseg_decode`

## Requirements
- R1: The privilege level is resolved with kernel taking precedence over supervisor, and supervisor over user. When no privilege flag is set, the result is always the error code.
- R2: With 32-bit addressing, the segment number is address bits [31:29] and address bits [63:32] have no effect on any output.
- R3: 32-bit kernel: segments 4 and 5 give the direct code with physical address {3'b000, va[28:0]}. Every other segment gives the TLB code with lookup address equal to va[31:0] sign-extended to 64 bits.
- R4: 32-bit supervisor: segments 0 to 3 and 6 give the TLB code with the sign-extended lookup address. Segments 4, 5 and 7 give the error code.
- R5: 32-bit user: segments 0 to 3 (va[31] = 0) give the TLB code with the sign-extended lookup address. All other addresses give the error code.
- R6: 64-bit user: addresses from 0 to 0x000000FFFFFFFFFF give the TLB code with lookup address equal to the full address. Every other address gives the error code.
- R7: 64-bit supervisor: addresses in 0x0000010000000000..0x3FFFFFFFFFFFFFFF, in 0x4000010000000000..0xFFFFFFFFBFFFFFFF, or at or above 0xFFFFFFFFE0000000 give the error code. Every other address gives the TLB code with the full address.
- R8: 64-bit kernel, TLB ranges: 0..0x000000FFFFFFFFFF, 0x4000000000000000..0x400000FFFFFFFFFF and 0xC000000000000000..0xC00000FF7FFFFFFF give the TLB code with the full address.
- R9: 64-bit kernel, top range: 0xFFFFFFFF80000000..0xFFFFFFFFBFFFFFFF gives the direct code with physical address {3'b000, va[28:0]}, and 0xFFFFFFFFC0000000 and above gives the TLB code. Every other address gives the error code.
- R10: The result code is 0 for TLB, 1 for direct and 2 for error, and is never 3. The physical address output is zero unless the code is direct. The lookup address output is zero unless the code is TLB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| va_i | input | 64 | Virtual address to classify |
| kern_i | input | 1 | Kernel privilege flag (highest precedence) |
| supv_i | input | 1 | Supervisor privilege flag |
| user_i | input | 1 | User privilege flag (lowest precedence) |
| wide_i | input | 1 | 1 selects 64-bit addressing, 0 selects 32-bit |
| res_o | output | 2 | Result code: 0 TLB, 1 direct, 2 error |
| pa_o | output | 32 | Unmapped physical address, valid for the direct code |
| tlb_va_o | output | 64 | Address to look up, valid for the TLB code |

## Verification
The hardest cases to reach are the exact edges of the 64-bit ranges. The kernel mapped range stops 2 GiB short of a power-of-two boundary, and the supervisor window sits between two refused gaps. A randomly chosen address almost never lands on the first or last byte of one of these ranges. The stimulus therefore drives addresses on both sides of every boundary under each privilege level. It also drives conflicting privilege flags, and 32-bit addresses with non-zero upper bits, to show that precedence holds and that the upper half is ignored.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  localparam int VA_W   = 64;
  localparam int A32_W  = 32;
  localparam int PA_W   = 32;
  localparam int SEG_W  = 3;
  localparam int SEG_N  = 1 << SEG_W;
  localparam int OFF_W  = A32_W - SEG_W;

  typedef enum logic [1:0] {
    RES_TLB    = 2'd0,
    RES_DIRECT = 2'd1,
    RES_ERROR  = 2'd2
  } vseg_res_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_KERN = 2'd1,
    LVL_SUPV = 2'd2,
    LVL_USER = 2'd3
  } vseg_lvl_e;

  // sign-extend the low word of an address to the full width
  function automatic logic [VA_W-1:0] f_sext32(input logic [A32_W-1:0] lo);
    return {{(VA_W-A32_W){lo[A32_W-1]}}, lo};
  endfunction

  // unmapped physical address: drop the segment bits
  function automatic logic [PA_W-1:0] f_direct_pa(input logic [A32_W-1:0] lo);
    return {{(PA_W-OFF_W){1'b0}}, lo[OFF_W-1:0]};
  endfunction

  // 32-bit segment permission table per privilege level
  function automatic vseg_res_e f_perm32(input vseg_lvl_e lvl, input logic [SEG_W-1:0] seg);
    vseg_res_e r;
    r = RES_ERROR;
    case (lvl)
      LVL_KERN: r = (seg == 3'd4 || seg == 3'd5) ? RES_DIRECT : RES_TLB;
      LVL_SUPV: r = (seg <= 3'd3 || seg == 3'd6) ? RES_TLB : RES_ERROR;
      LVL_USER: r = (seg <= 3'd3) ? RES_TLB : RES_ERROR;
      default:  r = RES_ERROR;
    endcase
    return r;
  endfunction

  function automatic logic f_in(input logic [VA_W-1:0] v,
                                input logic [VA_W-1:0] lo,
                                input logic [VA_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/vseg_lvl_sel.sv
module vseg_lvl_sel
  import vseg_pkg::*;
(
  input  logic      kern_i,
  input  logic      supv_i,
  input  logic      user_i,
  output vseg_lvl_e lvl_o
);
  always_comb begin
    if (kern_i)      lvl_o = LVL_KERN;
    else if (supv_i) lvl_o = LVL_SUPV;
    else if (user_i) lvl_o = LVL_USER;
    else             lvl_o = LVL_NONE;
  end
endmodule

// File: rtl/vseg_map32.sv
module vseg_map32
  import vseg_pkg::*;
(
  input  logic [A32_W-1:0] va_i,
  input  vseg_lvl_e        lvl_i,
  output vseg_res_e        res_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [VA_W-1:0]  tlb_o
);
  logic [SEG_W-1:0] seg;
  vseg_res_e        seg_res [SEG_N];

  assign seg = va_i[A32_W-1 -: SEG_W];

  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    assign seg_res[g] = f_perm32(lvl_i, SEG_W'(g));
  end

  assign res_o = seg_res[seg];
  assign pa_o  = (res_o == RES_DIRECT) ? f_direct_pa(va_i) : '0;
  assign tlb_o = (res_o == RES_TLB)    ? f_sext32(va_i)    : '0;
endmodule

// File: rtl/vseg_map64.sv
module vseg_map64
  import vseg_pkg::*;
#(
  parameter int REGION_BITS = 40
) (
  input  logic [VA_W-1:0] va_i,
  input  vseg_lvl_e       lvl_i,
  input  vseg_res_e       c32_res_i,
  input  logic [PA_W-1:0] c32_pa_i,
  output vseg_res_e       res_o,
  output logic [PA_W-1:0] pa_o,
  output logic [VA_W-1:0] tlb_o
);
  localparam logic [VA_W-1:0] SPAN    = VA_W'(1) << REGION_BITS;
  localparam logic [VA_W-1:0] XU_LO   = '0;
  localparam logic [VA_W-1:0] XU_HI   = SPAN - 1;
  localparam logic [VA_W-1:0] XS_LO   = 64'h4000_0000_0000_0000;
  localparam logic [VA_W-1:0] XS_HI   = XS_LO + SPAN - 1;
  localparam logic [VA_W-1:0] XK_LO   = 64'hC000_0000_0000_0000;
  localparam logic [VA_W-1:0] XK_HI   = XK_LO + SPAN - 1 - 64'h8000_0000;
  localparam logic [VA_W-1:0] CMP_LO  = 64'hFFFF_FFFF_8000_0000;
  localparam logic [VA_W-1:0] SWIN_LO = 64'hFFFF_FFFF_C000_0000;
  localparam logic [VA_W-1:0] SWIN_HI = 64'hFFFF_FFFF_DFFF_FFFF;

  logic hit_xu, hit_xs, hit_xk, hit_cmp, hit_swin;

  assign hit_xu   = f_in(va_i, XU_LO, XU_HI);
  assign hit_xs   = f_in(va_i, XS_LO, XS_HI);
  assign hit_xk   = f_in(va_i, XK_LO, XK_HI);
  assign hit_cmp  = (va_i >= CMP_LO);
  assign hit_swin = f_in(va_i, SWIN_LO, SWIN_HI);

  always_comb begin
    res_o = RES_ERROR;
    pa_o  = '0;
    case (lvl_i)
      LVL_USER: res_o = hit_xu ? RES_TLB : RES_ERROR;
      LVL_SUPV: res_o = (hit_xu || hit_xs || hit_swin) ? RES_TLB : RES_ERROR;
      LVL_KERN: begin
        if (hit_xu || hit_xs || hit_xk) begin
          res_o = RES_TLB;
        end else if (hit_cmp) begin
          res_o = c32_res_i;
          pa_o  = c32_pa_i;
        end
      end
      default: res_o = RES_ERROR;
    endcase
  end

  assign tlb_o = (res_o == RES_TLB) ? va_i : '0;
endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
#(
  parameter int REGION_BITS = 40
) (
  input  logic [63:0] va_i,
  input  logic        kern_i,
  input  logic        supv_i,
  input  logic        user_i,
  input  logic        wide_i,
  output logic [1:0]  res_o,
  output logic [31:0] pa_o,
  output logic [63:0] tlb_va_o
);
  vseg_lvl_e        lvl_w;
  vseg_res_e        r32_w, r64_w;
  logic [PA_W-1:0]  pa32_w, pa64_w;
  logic [VA_W-1:0]  tlb32_w, tlb64_w;

  vseg_lvl_sel u_lvl (
    .kern_i (kern_i),
    .supv_i (supv_i),
    .user_i (user_i),
    .lvl_o  (lvl_w)
  );

  vseg_map32 u_m32 (
    .va_i  (va_i[A32_W-1:0]),
    .lvl_i (lvl_w),
    .res_o (r32_w),
    .pa_o  (pa32_w),
    .tlb_o (tlb32_w)
  );

  vseg_map64 #(.REGION_BITS(REGION_BITS)) u_m64 (
    .va_i      (va_i),
    .lvl_i     (lvl_w),
    .c32_res_i (r32_w),
    .c32_pa_i  (pa32_w),
    .res_o     (r64_w),
    .pa_o      (pa64_w),
    .tlb_o     (tlb64_w)
  );

  assign res_o    = wide_i ? r64_w   : r32_w;
  assign pa_o     = wide_i ? pa64_w  : pa32_w;
  assign tlb_va_o = wide_i ? tlb64_w : tlb32_w;
endmodule

// File: rtl/vseg_decode_chk.sv
module vseg_decode_chk (
  input logic [63:0] va_i,
  input logic        kern_i,
  input logic        supv_i,
  input logic        user_i,
  input logic        wide_i,
  input logic [1:0]  res_o,
  input logic [31:0] pa_o,
  input logic [63:0] tlb_va_o
);
  logic only_user, only_supv;
  assign only_user = !kern_i && !supv_i && user_i;
  assign only_supv = !kern_i && supv_i;

  always_comb begin
    AST_CODE_LEGAL: assert (res_o != 2'd3) else $error("illegal code"); // R10
    AST_PA_IDLE: assert (res_o == 2'd1 || pa_o == 32'd0) else $error("stray pa"); // R10
    AST_LOOKUP_IDLE: assert (res_o == 2'd0 || tlb_va_o == 64'd0) else $error("stray lookup"); // R10
    AST_NO_LEVEL_ERR: assert (kern_i || supv_i || user_i || res_o == 2'd2) else $error("no level"); // R1
    AST_DIRECT_KERNEL: assert (res_o != 2'd1 || kern_i) else $error("direct outside kernel"); // R3
    AST_SUPV32_GAP: assert (!(only_supv && !wide_i && (va_i[31:29] == 3'd4 || va_i[31:29] == 3'd5 || va_i[31:29] == 3'd7)) || res_o == 2'd2) else $error("supv gap"); // R4
    AST_USER32_LOW: assert (!(only_user && !wide_i && res_o == 2'd0) || !va_i[31]) else $error("user high"); // R5
    AST_USER64_LOW: assert (!(only_user && wide_i && res_o == 2'd0) || va_i[63:40] == 24'd0) else $error("user64 high"); // R6
    AST_NARROW_SEXT: assert (wide_i || res_o != 2'd0 || tlb_va_o == {{32{va_i[31]}}, va_i[31:0]}) else $error("sext"); // R2
  end
endmodule

bind vseg_decode vseg_decode_chk u_chk (.*);

// File: tb/vseg_decode_bench.sv
module vseg_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] va_i = '0;
  logic        kern_i = 1'b0, supv_i = 1'b0, user_i = 1'b0, wide_i = 1'b0;
  logic [1:0]  res_o;
  logic [31:0] pa_o;
  logic [63:0] tlb_va_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0]  r;
    logic [31:0] pa;
    logic [63:0] ta;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  vseg_decode u_vseg_decode (
    .va_i(va_i), .kern_i(kern_i), .supv_i(supv_i), .user_i(user_i), .wide_i(wide_i),
    .res_o(res_o), .pa_o(pa_o), .tlb_va_o(tlb_va_o)
  );

  function automatic exp_t predict(input logic [63:0] va, input logic k, s, u, w, input string tag);
    exp_t e;
    int lvl;
    logic [2:0] seg;
    logic [63:0] sx;
    logic gap;
    e.r = 2'd2; e.pa = '0; e.ta = '0; e.tag = tag;
    lvl = k ? 1 : (s ? 2 : (u ? 3 : 0));
    seg = va[31:29];
    sx  = {{32{va[31]}}, va[31:0]};
    if (!w) begin
      if (lvl == 1) begin
        if (seg == 3'd4 || seg == 3'd5) begin e.r = 2'd1; e.pa = {3'b000, va[28:0]}; end
        else begin e.r = 2'd0; e.ta = sx; end
      end else if (lvl == 2) begin
        if (seg < 3'd4 || seg == 3'd6) begin e.r = 2'd0; e.ta = sx; end
      end else if (lvl == 3) begin
        if (!va[31]) begin e.r = 2'd0; e.ta = sx; end
      end
    end else begin
      if (lvl == 3) begin
        if (va <= 64'h0000_00FF_FFFF_FFFF) begin e.r = 2'd0; e.ta = va; end
      end else if (lvl == 2) begin
        gap = (va >= 64'h0000_0100_0000_0000 && va <= 64'h3FFF_FFFF_FFFF_FFFF) ||
              (va >= 64'h4000_0100_0000_0000 && va <= 64'hFFFF_FFFF_BFFF_FFFF) ||
              (va >= 64'hFFFF_FFFF_E000_0000);
        if (!gap) begin e.r = 2'd0; e.ta = va; end
      end else if (lvl == 1) begin
        if (va <= 64'h0000_00FF_FFFF_FFFF ||
            (va >= 64'h4000_0000_0000_0000 && va <= 64'h4000_00FF_FFFF_FFFF) ||
            (va >= 64'hC000_0000_0000_0000 && va <= 64'hC000_00FF_7FFF_FFFF) ||
            va >= 64'hFFFF_FFFF_C000_0000) begin
          e.r = 2'd0; e.ta = va;
        end else if (va >= 64'hFFFF_FFFF_8000_0000) begin
          e.r = 2'd1; e.pa = {3'b000, va[28:0]};
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [63:0] va, input logic k, s, u, w, input string tag);
    @(negedge clk);
    va_i = va; kern_i = k; supv_i = s; user_i = u; wide_i = w;
    sb.push_back(predict(va, k, s, u, w, tag));
  endtask

  // monitor: outputs settled half a period after the driver's edge
  always @(posedge clk) begin
    if (sb.size() > 0 && !finished) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (res_o !== e.r || pa_o !== e.pa || tlb_va_o !== e.ta) begin
        bad++;
        $display("FAIL %s va=%h: res=%0d pa=%h tlb=%h expected res=%0d pa=%h tlb=%h",
                 e.tag, va_i, res_o, pa_o, tlb_va_o, e.r, e.pa, e.ta);
      end
    end
  end

  initial begin
    // reset state: no privilege flag set, error code expected (R1, R10)
    @(negedge clk);
    sb.push_back(predict(64'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset"));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 precedence with conflicting flags
    drive(64'h0000_0000_8000_0000, 1, 1, 1, 0, "R1 all flags");
    drive(64'h0000_0000_8000_0000, 0, 1, 1, 0, "R1 supv over user");
    drive(64'h0000_0000_E000_0000, 0, 1, 1, 0, "R1 supv over user");
    drive(64'h0000_0000_1000_0000, 0, 0, 0, 0, "R1 no level");
    drive(64'h0000_0000_0000_0000, 0, 0, 0, 1, "R1 no level wide");
    // R2 upper half ignored in 32-bit addressing
    drive(64'hDEAD_BEEF_A000_1234, 1, 0, 0, 0, "R2 high bits");
    drive(64'h0000_0000_A000_1234, 1, 0, 0, 0, "R2 high bits clear");
    drive(64'h1234_5678_2000_0040, 0, 0, 1, 0, "R2 user sext");
    drive(64'hFFFF_FFFF_C000_0010, 0, 1, 0, 0, "R2 supv sext");
    // R3 R4 R5 every segment
    for (int sg = 0; sg < 8; sg++) begin
      drive({32'h0, sg[2:0], 29'h0ABC_DEF}, 1, 0, 0, 0, "R3 kernel seg");
      drive({32'h0, sg[2:0], 29'h1FFF_FFFF}, 0, 1, 0, 0, "R4 supv seg");
      drive({32'h0, sg[2:0], 29'h0000_0000}, 0, 0, 1, 0, "R5 user seg");
    end
    // R6 64-bit user edges
    drive(64'h0000_00FF_FFFF_FFFF, 0, 0, 1, 1, "R6 top of user");
    drive(64'h0000_0100_0000_0000, 0, 0, 1, 1, "R6 above user");
    drive(64'hFFFF_FFFF_8000_0000, 0, 0, 1, 1, "R6 top range");
    // R7 64-bit supervisor edges
    drive(64'h0000_00FF_FFFF_FFFF, 0, 1, 0, 1, "R7 user window");
    drive(64'h0000_0100_0000_0000, 0, 1, 0, 1, "R7 gap1 start");
    drive(64'h3FFF_FFFF_FFFF_FFFF, 0, 1, 0, 1, "R7 gap1 end");
    drive(64'h4000_0000_0000_0000, 0, 1, 0, 1, "R7 supv start");
    drive(64'h4000_00FF_FFFF_FFFF, 0, 1, 0, 1, "R7 supv end");
    drive(64'h4000_0100_0000_0000, 0, 1, 0, 1, "R7 gap2 start");
    drive(64'hFFFF_FFFF_BFFF_FFFF, 0, 1, 0, 1, "R7 gap2 end");
    drive(64'hFFFF_FFFF_C000_0000, 0, 1, 0, 1, "R7 window start");
    drive(64'hFFFF_FFFF_DFFF_FFFF, 0, 1, 0, 1, "R7 window end");
    drive(64'hFFFF_FFFF_E000_0000, 0, 1, 0, 1, "R7 gap3 start");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 1, "R7 gap3 end");
    // R8 64-bit kernel mapped ranges
    drive(64'h0000_0000_0000_0000, 1, 0, 0, 1, "R8 zero");
    drive(64'h4000_00FF_FFFF_FFFF, 1, 0, 0, 1, "R8 supv range end");
    drive(64'h4000_0100_0000_0000, 1, 0, 0, 1, "R8 past supv range");
    drive(64'hC000_0000_0000_0000, 1, 0, 0, 1, "R8 kseg start");
    drive(64'hC000_00FF_7FFF_FFFF, 1, 0, 0, 1, "R8 kseg end");
    drive(64'hC000_00FF_8000_0000, 1, 0, 0, 1, "R8 past kseg");
    drive(64'h8000_0000_0000_0000, 1, 0, 0, 1, "R8 physical hole");
    // R9 kernel top range
    drive(64'hFFFF_FFFF_7FFF_FFFF, 1, 0, 0, 1, "R9 below top");
    drive(64'hFFFF_FFFF_8000_0000, 1, 0, 0, 1, "R9 direct start");
    drive(64'hFFFF_FFFF_BFFF_FFFF, 1, 0, 0, 1, "R9 direct end");
    drive(64'hFFFF_FFFF_C000_0000, 1, 0, 0, 1, "R9 mapped top");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 1, "R9 last byte");
    // R10 code and field cleanliness after a direct result
    drive(64'hFFFF_FFFF_A123_4567, 1, 0, 0, 1, "R10 direct fields");
    drive(64'h0000_0000_A123_4567, 0, 0, 1, 0, "R10 error fields");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule